// File: doc/BRIEF.md
# Paired Transmit/Receive Byte FIFO with Thresholds and Self-Clearing Flush

This block holds the data path between a register-mapped host and a serial bus engine. The host pushes bytes into a transmit queue that the engine drains, and the engine pushes received bytes into a receive queue that the host reads. Each queue reports its fill level and four level flags: empty, full, nearly empty and nearly full. The two nearly flags are set against a 4-bit threshold that the host programs separately for each queue. A write that hits a full transmit queue is dropped and raises a sticky overrun flag.

Either queue can be emptied by a flush request. An accepted request clears the queue at once and then holds a busy bit for `FLUSH_CYC` cycles. The busy bit clears itself, and the host polls it. While the busy bit is set, every push, pop and overrun event on that queue is ignored. An enable input gates all pushes and pops made by the engine, and leaves the host side untouched.

The depth is a parameter (16 or 32 entries). The largest threshold that makes sense is depth/2 − 1, but the threshold registers store any 4-bit value.

Top module: `sbf_fifo_pair`

## Requirements
- R1: After reset both queues are empty (level 0, empty=1, full=0), both thresholds are 0, both busy bits are 0 and `tx_ovr` is 0.
- R2: Bytes written with `host_tx_wr` leave in the order written, through `eng_tx_pop`. `eng_tx_data` shows the oldest byte, or 0 when the transmit queue is empty. A pop of an empty transmit queue is ignored.
- R3: Bytes pushed with `eng_rx_push` reach the host in the order pushed. `host_rx_rdata` shows the oldest byte, or 0 when the receive queue is empty. A read of an empty receive queue returns 0 and does not move the queue.
- R4: `tx_level`/`rx_level` give the entry count. Empty is set when the count is 0, and full is set when the count equals `DEPTH`.
- R5: For each queue, nearly empty is set when the count is ≤ that queue's threshold, and nearly full is set when the count is ≥ that queue's threshold.
- R6: `tx_thr_wr` / `rx_thr_wr` load `thr_wdata` (4 bits, 0 to 15) into the matching threshold register. The new value applies from the next cycle.
- R7: A host write while the transmit queue is full is discarded and sets `tx_ovr`. `tx_ovr` stays set until `tx_ovr_clr`, or until an accepted transmit flush. When a new overrun and `tx_ovr_clr` occur in the same cycle, the flag stays set.
- R8: An engine push while the receive queue is full is discarded, and the stored bytes are kept.
- R9: While `eng_en` is 0, `eng_tx_pop` and `eng_rx_push` have no effect.
- R10: A flush request made while that queue's busy bit is 0 empties the queue at that clock edge. The busy bit is then 1 for exactly `FLUSH_CYC` cycles and returns to 0 by itself. A request made while the busy bit is 1 is ignored.
- R11: In the cycle a flush is accepted, and while its busy bit is 1, pushes, pops and overrun events on that queue are ignored.
- R12: A push and a pop on the same queue in one cycle both take effect, as long as the queue is neither full nor empty. In that case the level is unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| eng_en | input | 1 | Gates engine-side pop and push |
| host_tx_wr | input | 1 | Host write strobe, transmit queue |
| host_tx_wdata | input | DW | Host write byte |
| host_rx_rd | input | 1 | Host read strobe, receive queue |
| host_rx_rdata | output | DW | Oldest receive byte, 0 when empty |
| eng_tx_pop | input | 1 | Engine pop strobe, transmit queue |
| eng_tx_data | output | DW | Oldest transmit byte, 0 when empty |
| eng_rx_push | input | 1 | Engine push strobe, receive queue |
| eng_rx_data | input | DW | Engine push byte |
| tx_thr_wr | input | 1 | Load transmit threshold |
| rx_thr_wr | input | 1 | Load receive threshold |
| thr_wdata | input | THR_W | Threshold value |
| tx_flush_req | input | 1 | Request a transmit flush |
| rx_flush_req | input | 1 | Request a receive flush |
| tx_flush_busy | output | 1 | Transmit flush in progress |
| rx_flush_busy | output | 1 | Receive flush in progress |
| tx_ovr_clr | input | 1 | Clear the overrun flag |
| tx_ovr | output | 1 | Sticky transmit overrun |
| tx_level | output | CW | Transmit entry count, CW = $clog2(DEPTH+1) |
| rx_level | output | CW | Receive entry count |
| tx_empty | output | 1 | Transmit queue empty |
| tx_nempty | output | 1 | Transmit count ≤ transmit threshold |
| tx_nfull | output | 1 | Transmit count ≥ transmit threshold |
| tx_full | output | 1 | Transmit queue full |
| rx_empty | output | 1 | Receive queue empty |
| rx_nempty | output | 1 | Receive count ≤ receive threshold |
| rx_nfull | output | 1 | Receive count ≥ receive threshold |
| rx_full | output | 1 | Receive queue full |

## Verification
The assertions check some properties on every cycle:
- a queue whose busy bit is set has a level of 0;
- a flush never stays busy longer than `FLUSH_CYC` cycles;
- a write into a full transmit queue always leaves the overrun flag set;
- the transmit level holds still while the engine is disabled and the host is idle;
- a full receive queue stays full until a read or a flush;
- an empty receive queue presents a zero byte.

Some behaviours need the bench's queue model and its scenarios:
- byte ordering through both queues;
- the exact threshold compares after reprogramming;
- priority between overrun and overrun clear;
- the exact cycle at which the busy bit falls;
- push and pop in the same cycle.

// File: rtl/sbf_pkg.sv
package sbf_pkg;

  typedef enum int {
    CH_TX = 0,
    CH_RX = 1
  } sbf_chan_e;

  localparam int NUM_CH = 2;

  // next read/write slot with wrap at the queue depth
  function automatic int unsigned ptr_next(input int unsigned p, input int unsigned depth);
    return (p + 1 == depth) ? 0 : p + 1;
  endfunction

  // level is at or below the threshold (nearly-empty rule)
  function automatic logic lvl_low(input int unsigned lvl, input int unsigned thr);
    return lvl <= thr;
  endfunction

  // level is at or above the threshold (nearly-full rule)
  function automatic logic lvl_high(input int unsigned lvl, input int unsigned thr);
    return lvl >= thr;
  endfunction

endpackage

// File: rtl/sbf_flush_seq.sv
module sbf_flush_seq #(
  parameter int CYC = 4,
  localparam int TW = $clog2(CYC + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic req,
  output logic clr,
  output logic busy
);

  logic [TW-1:0] remain;

  // a request is taken only while idle; clr is the accept pulse
  assign busy = (remain != '0);
  assign clr  = req && !busy;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      remain <= '0;
    end else if (clr) begin
      remain <= TW'(CYC);
    end else if (busy) begin
      remain <= remain - 1'b1;
    end
  end

endmodule

// File: rtl/sbf_thr_reg.sv
module sbf_thr_reg #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] thr
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      thr <= '0;
    end else if (wr) begin
      thr <= wdata;
    end
  end

endmodule

// File: rtl/sbf_byte_queue.sv
module sbf_byte_queue #(
  parameter int DEPTH = 16,
  parameter int DW    = 8,
  parameter int THR_W = 4,
  localparam int AW = $clog2(DEPTH),
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             push,
  input  logic [DW-1:0]    push_data,
  input  logic             pop,
  input  logic [THR_W-1:0] thr,
  output logic [DW-1:0]    head,
  output logic [CW-1:0]    level,
  output logic             empty,
  output logic             nempty,
  output logic             nfull,
  output logic             full,
  output logic             push_drop
);

  logic [DW-1:0] mem [DEPTH];
  logic [AW-1:0] wr_ptr;
  logic [AW-1:0] rd_ptr;
  logic          do_push;
  logic          do_pop;

  assign empty     = (level == '0);
  assign full      = (level == CW'(DEPTH));
  assign nempty    = sbf_pkg::lvl_low(32'(level), 32'(thr));
  assign nfull     = sbf_pkg::lvl_high(32'(level), 32'(thr));
  assign do_push   = push && !full && !clr;
  assign do_pop    = pop && !empty && !clr;
  assign push_drop = push && full && !clr;
  assign head      = empty ? '0 : mem[rd_ptr];

  always_ff @(posedge clk) begin
    if (do_push) begin
      mem[wr_ptr] <= push_data;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      level  <= '0;
    end else if (clr) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      level  <= '0;
    end else begin
      if (do_push) begin
        wr_ptr <= AW'(sbf_pkg::ptr_next(32'(wr_ptr), DEPTH));
      end
      if (do_pop) begin
        rd_ptr <= AW'(sbf_pkg::ptr_next(32'(rd_ptr), DEPTH));
      end
      case ({do_push, do_pop})
        2'b10:   level <= level + 1'b1;
        2'b01:   level <= level - 1'b1;
        default: level <= level;
      endcase
    end
  end

endmodule

// File: rtl/sbf_fifo_pair.sv
module sbf_fifo_pair #(
  parameter int DEPTH     = 16,
  parameter int DW        = 8,
  parameter int THR_W     = 4,
  parameter int FLUSH_CYC = 4,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             eng_en,
  input  logic             host_tx_wr,
  input  logic [DW-1:0]    host_tx_wdata,
  input  logic             host_rx_rd,
  output logic [DW-1:0]    host_rx_rdata,
  input  logic             eng_tx_pop,
  output logic [DW-1:0]    eng_tx_data,
  input  logic             eng_rx_push,
  input  logic [DW-1:0]    eng_rx_data,
  input  logic             tx_thr_wr,
  input  logic             rx_thr_wr,
  input  logic [THR_W-1:0] thr_wdata,
  input  logic             tx_flush_req,
  input  logic             rx_flush_req,
  output logic             tx_flush_busy,
  output logic             rx_flush_busy,
  input  logic             tx_ovr_clr,
  output logic             tx_ovr,
  output logic [CW-1:0]    tx_level,
  output logic [CW-1:0]    rx_level,
  output logic             tx_empty,
  output logic             tx_nempty,
  output logic             tx_nfull,
  output logic             tx_full,
  output logic             rx_empty,
  output logic             rx_nempty,
  output logic             rx_nfull,
  output logic             rx_full
);

  import sbf_pkg::*;

  logic [NUM_CH-1:0] flush_req_v;
  logic [NUM_CH-1:0] flush_clr_v;
  logic [NUM_CH-1:0] flush_busy_v;
  logic [NUM_CH-1:0] thr_wr_v;
  logic [NUM_CH-1:0] hold_v;
  logic [THR_W-1:0]  thr_v [NUM_CH];

  assign flush_req_v[CH_TX] = tx_flush_req;
  assign flush_req_v[CH_RX] = rx_flush_req;
  assign thr_wr_v[CH_TX]    = tx_thr_wr;
  assign thr_wr_v[CH_RX]    = rx_thr_wr;

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    sbf_flush_seq #(.CYC(FLUSH_CYC)) u_seq (
      .clk  (clk),
      .rst_n(rst_n),
      .req  (flush_req_v[c]),
      .clr  (flush_clr_v[c]),
      .busy (flush_busy_v[c])
    );
    sbf_thr_reg #(.W(THR_W)) u_thr (
      .clk  (clk),
      .rst_n(rst_n),
      .wr   (thr_wr_v[c]),
      .wdata(thr_wdata),
      .thr  (thr_v[c])
    );
    // queue is frozen in the accept cycle and for the whole busy window
    assign hold_v[c] = flush_busy_v[c] | flush_clr_v[c];
  end

  assign tx_flush_busy = flush_busy_v[CH_TX];
  assign rx_flush_busy = flush_busy_v[CH_RX];

  // named gated events, visible to the checker
  logic tx_push_ev, tx_pop_ev, rx_push_ev, rx_pop_ev, tx_drop_ev, rx_drop_ev;

  assign tx_push_ev = host_tx_wr && !hold_v[CH_TX];
  assign tx_pop_ev  = eng_en && eng_tx_pop && !hold_v[CH_TX];
  assign rx_push_ev = eng_en && eng_rx_push && !hold_v[CH_RX];
  assign rx_pop_ev  = host_rx_rd && !hold_v[CH_RX];

  sbf_byte_queue #(.DEPTH(DEPTH), .DW(DW), .THR_W(THR_W)) u_txq (
    .clk      (clk),
    .rst_n    (rst_n),
    .clr      (flush_clr_v[CH_TX]),
    .push     (tx_push_ev),
    .push_data(host_tx_wdata),
    .pop      (tx_pop_ev),
    .thr      (thr_v[CH_TX]),
    .head     (eng_tx_data),
    .level    (tx_level),
    .empty    (tx_empty),
    .nempty   (tx_nempty),
    .nfull    (tx_nfull),
    .full     (tx_full),
    .push_drop(tx_drop_ev)
  );

  sbf_byte_queue #(.DEPTH(DEPTH), .DW(DW), .THR_W(THR_W)) u_rxq (
    .clk      (clk),
    .rst_n    (rst_n),
    .clr      (flush_clr_v[CH_RX]),
    .push     (rx_push_ev),
    .push_data(eng_rx_data),
    .pop      (rx_pop_ev),
    .thr      (thr_v[CH_RX]),
    .head     (host_rx_rdata),
    .level    (rx_level),
    .empty    (rx_empty),
    .nempty   (rx_nempty),
    .nfull    (rx_nfull),
    .full     (rx_full),
    .push_drop(rx_drop_ev)
  );

  // sticky overrun: flush clears, a new drop beats a clear
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_ovr <= 1'b0;
    end else if (flush_clr_v[CH_TX]) begin
      tx_ovr <= 1'b0;
    end else if (tx_drop_ev) begin
      tx_ovr <= 1'b1;
    end else if (tx_ovr_clr) begin
      tx_ovr <= 1'b0;
    end
  end

endmodule

// File: rtl/sbf_fifo_pair_chk.sv
module sbf_fifo_pair_chk #(
  parameter int DEPTH     = 16,
  parameter int DW        = 8,
  parameter int FLUSH_CYC = 4,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          eng_en,
  input logic          host_tx_wr,
  input logic          host_rx_rd,
  input logic          tx_flush_req,
  input logic          rx_flush_req,
  input logic          tx_flush_busy,
  input logic          rx_flush_busy,
  input logic          tx_ovr,
  input logic [CW-1:0] tx_level,
  input logic [CW-1:0] rx_level,
  input logic          tx_full,
  input logic          rx_full,
  input logic [DW-1:0] host_rx_rdata,
  input logic          rx_empty
);

  int unsigned tx_run, rx_run;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_run <= 0;
      rx_run <= 0;
    end else begin
      tx_run <= tx_flush_busy ? tx_run + 1 : 0;
      rx_run <= rx_flush_busy ? rx_run + 1 : 0;
    end
  end

  // R10: a busy queue holds nothing
  a_r10_tx_busy_empty: assert property (@(posedge clk) disable iff (!rst_n)
    tx_flush_busy |-> (tx_level == '0));
  a_r10_rx_busy_empty: assert property (@(posedge clk) disable iff (!rst_n)
    rx_flush_busy |-> (rx_level == '0));

  // R10: busy window never outlasts the programmed length
  a_r10_tx_busy_len: assert property (@(posedge clk) disable iff (!rst_n)
    tx_run <= FLUSH_CYC);
  a_r10_rx_busy_len: assert property (@(posedge clk) disable iff (!rst_n)
    rx_run <= FLUSH_CYC);

  // R7: a write into a full, idle transmit queue leaves overrun set
  a_r7_ovr_on_full_write: assert property (@(posedge clk) disable iff (!rst_n)
    (host_tx_wr && tx_full && !tx_flush_busy && !tx_flush_req) |=> tx_ovr);

  // R9: engine disabled and host idle keep the transmit level
  a_r9_tx_level_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!eng_en && !host_tx_wr && !tx_flush_req) |=> $stable(tx_level));

  // R8: a full receive queue stays full without a read or a flush
  a_r8_rx_full_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_full && !host_rx_rd && !rx_flush_req) |=> rx_full);

  // R3: empty receive queue presents zero
  a_r3_rx_empty_zero: assert property (@(posedge clk) disable iff (!rst_n)
    rx_empty |-> (host_rx_rdata == '0));

endmodule

bind sbf_fifo_pair sbf_fifo_pair_chk #(
  .DEPTH(DEPTH), .DW(DW), .FLUSH_CYC(FLUSH_CYC)
) chk_i (.*);

// File: tb/sbf_fifo_pair_tb_top.sv
module sbf_fifo_pair_tb_top;
  localparam int D  = 16;
  localparam int FC = 4;
  localparam int CW = $clog2(D + 1);

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic rst_n;
  logic eng_en, host_tx_wr, host_rx_rd, eng_tx_pop, eng_rx_push;
  logic tx_thr_wr, rx_thr_wr, tx_flush_req, rx_flush_req, tx_ovr_clr;
  logic [7:0] host_tx_wdata, eng_rx_data, host_rx_rdata, eng_tx_data;
  logic [3:0] thr_wdata;
  logic tx_flush_busy, rx_flush_busy, tx_ovr;
  logic [CW-1:0] tx_level, rx_level;
  logic tx_empty, tx_nempty, tx_nfull, tx_full, rx_empty, rx_nempty, rx_nfull, rx_full;

  sbf_fifo_pair #(.DEPTH(D), .FLUSH_CYC(FC)) dut_i (
    .clk(clk), .rst_n(rst_n), .eng_en(eng_en),
    .host_tx_wr(host_tx_wr), .host_tx_wdata(host_tx_wdata),
    .host_rx_rd(host_rx_rd), .host_rx_rdata(host_rx_rdata),
    .eng_tx_pop(eng_tx_pop), .eng_tx_data(eng_tx_data),
    .eng_rx_push(eng_rx_push), .eng_rx_data(eng_rx_data),
    .tx_thr_wr(tx_thr_wr), .rx_thr_wr(rx_thr_wr), .thr_wdata(thr_wdata),
    .tx_flush_req(tx_flush_req), .rx_flush_req(rx_flush_req),
    .tx_flush_busy(tx_flush_busy), .rx_flush_busy(rx_flush_busy),
    .tx_ovr_clr(tx_ovr_clr), .tx_ovr(tx_ovr),
    .tx_level(tx_level), .rx_level(rx_level),
    .tx_empty(tx_empty), .tx_nempty(tx_nempty), .tx_nfull(tx_nfull), .tx_full(tx_full),
    .rx_empty(rx_empty), .rx_nempty(rx_nempty), .rx_nfull(rx_nfull), .rx_full(rx_full)
  );

  // behavioural reference
  byte unsigned tq[$];
  byte unsigned rq[$];
  int  tbusy = 0, rbusy = 0, tthr = 0, rthr = 0;
  bit  tovr = 0;
  int  vec = 0, bad = 0;
  string tag = "R1";
  bit  done = 0;

  always @(posedge clk) begin
    if (!rst_n) begin
      tq.delete(); rq.delete();
      tbusy = 0; rbusy = 0; tthr = 0; rthr = 0; tovr = 0;
    end else begin
      // transmit side
      if (tbusy == 0 && tx_flush_req) begin
        tq.delete(); tbusy = FC; tovr = 0;
      end else if (tbusy > 0) begin
        tbusy--;
        if (tx_ovr_clr) tovr = 0;
      end else begin
        bit was_full;
        was_full = (tq.size() == D);
        if (eng_en && eng_tx_pop && tq.size() > 0) void'(tq.pop_front());
        if (host_tx_wr && was_full) tovr = 1;
        else if (tx_ovr_clr) tovr = 0;
        if (host_tx_wr && !was_full) tq.push_back(host_tx_wdata);
      end
      // receive side
      if (rbusy == 0 && rx_flush_req) begin
        rq.delete(); rbusy = FC;
      end else if (rbusy > 0) begin
        rbusy--;
      end else begin
        bit was_full;
        was_full = (rq.size() == D);
        if (host_rx_rd && rq.size() > 0) void'(rq.pop_front());
        if (eng_en && eng_rx_push && !was_full) rq.push_back(eng_rx_data);
      end
      if (tx_thr_wr) tthr = thr_wdata;
      if (rx_thr_wr) rthr = thr_wdata;
    end
  end

  task automatic cmp(string what, int act, int exp);
    if (act !== exp) begin
      bad++;
      $display("FAIL [%s] %s: actual %0d expected %0d at %0t", tag, what, act, exp, $time);
    end
  endtask

  task automatic chk_all();
    int tl, rl;
    tl = tq.size();
    rl = rq.size();
    vec++;
    cmp("R4 tx_level", int'(tx_level), tl);
    cmp("R4 rx_level", int'(rx_level), rl);
    cmp("R4 tx_empty", int'(tx_empty), int'(tl == 0));
    cmp("R4 tx_full", int'(tx_full), int'(tl == D));
    cmp("R4 rx_empty", int'(rx_empty), int'(rl == 0));
    cmp("R4 rx_full", int'(rx_full), int'(rl == D));
    cmp("R5 R6 tx_nempty", int'(tx_nempty), int'(tl <= tthr));
    cmp("R5 R6 tx_nfull", int'(tx_nfull), int'(tl >= tthr));
    cmp("R5 R6 rx_nempty", int'(rx_nempty), int'(rl <= rthr));
    cmp("R5 R6 rx_nfull", int'(rx_nfull), int'(rl >= rthr));
    cmp("R2 eng_tx_data", int'(eng_tx_data), (tl > 0) ? int'(tq[0]) : 0);
    cmp("R3 host_rx_rdata", int'(host_rx_rdata), (rl > 0) ? int'(rq[0]) : 0);
    cmp("R7 tx_ovr", int'(tx_ovr), int'(tovr));
    cmp("R10 tx_flush_busy", int'(tx_flush_busy), int'(tbusy != 0));
    cmp("R10 rx_flush_busy", int'(rx_flush_busy), int'(rbusy != 0));
  endtask

  task automatic clear_strobes();
    host_tx_wr = 0; host_rx_rd = 0; eng_tx_pop = 0; eng_rx_push = 0;
    tx_thr_wr = 0; rx_thr_wr = 0; tx_flush_req = 0; rx_flush_req = 0; tx_ovr_clr = 0;
  endtask

  // one clock edge with the currently driven strobes, then compare
  task automatic tick();
    @(posedge clk);
    @(negedge clk);
    chk_all();
    clear_strobes();
  endtask

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", vec, bad);
  endtask

  initial begin
    #2000000;
    if (!done) begin
      bad++;
      $display("FAIL [watchdog] run did not finish: actual hung expected done");
      summary();
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0;
    eng_en = 0; host_tx_wdata = 0; eng_rx_data = 0; thr_wdata = 0;
    clear_strobes();
    // R1: reset state
    tag = "R1";
    tick(); tick();
    rst_n = 1'b1;
    tick();

    // R6: program thresholds
    tag = "R6";
    thr_wdata = 4'd3; tx_thr_wr = 1; tick();
    thr_wdata = 4'd5; rx_thr_wr = 1; tick();

    // R2 R4 R5: fill transmit queue to full, engine disabled
    tag = "R2 R4 R5";
    for (int i = 0; i < D; i++) begin
      host_tx_wr = 1; host_tx_wdata = 8'(i * 7 + 1); tick();
    end
    // R7: overrun on full writes, then clear; same-cycle drop beats clear
    tag = "R7";
    host_tx_wr = 1; host_tx_wdata = 8'hEE; tick();
    tx_ovr_clr = 1; tick();
    host_tx_wr = 1; host_tx_wdata = 8'hDD; tx_ovr_clr = 1; tick();
    tx_ovr_clr = 1; tick();

    // R9: engine strobes ignored while disabled
    tag = "R9";
    for (int i = 0; i < 3; i++) begin
      eng_tx_pop = 1; eng_rx_push = 1; eng_rx_data = 8'h55; tick();
    end

    // R2: drain in order, extra pops on empty ignored
    tag = "R2";
    eng_en = 1;
    for (int i = 0; i < D + 2; i++) begin
      eng_tx_pop = 1; tick();
    end

    // R3 R8: receive fill past full, then read past empty
    tag = "R3 R8";
    for (int i = 0; i < D + 2; i++) begin
      eng_rx_push = 1; eng_rx_data = 8'(8'hA0 + i); tick();
    end
    for (int i = 0; i < D + 2; i++) begin
      host_rx_rd = 1; tick();
    end

    // R12: simultaneous push and pop on both queues
    tag = "R12";
    for (int i = 0; i < 3; i++) begin
      host_tx_wr = 1; host_tx_wdata = 8'(8'h30 + i);
      eng_rx_push = 1; eng_rx_data = 8'(8'h40 + i); tick();
    end
    for (int i = 0; i < 5; i++) begin
      host_tx_wr = 1; host_tx_wdata = 8'(8'h60 + i); eng_tx_pop = 1;
      eng_rx_push = 1; eng_rx_data = 8'(8'h70 + i); host_rx_rd = 1; tick();
    end

    // R10 R11: flush with accesses in the accept cycle and during busy
    tag = "R10 R11";
    tx_flush_req = 1; host_tx_wr = 1; host_tx_wdata = 8'h99; eng_tx_pop = 1; tick();
    for (int i = 0; i < FC; i++) begin
      host_tx_wr = 1; host_tx_wdata = 8'h11; eng_tx_pop = 1; tx_flush_req = 1; tick();
    end
    host_tx_wr = 1; host_tx_wdata = 8'h22; tick();
    rx_flush_req = 1; host_rx_rd = 1; eng_rx_push = 1; eng_rx_data = 8'h33; tick();
    for (int i = 0; i < FC + 1; i++) begin
      eng_rx_push = 1; eng_rx_data = 8'h44; host_rx_rd = 1; tick();
    end
    // R7: flush clears a pending overrun
    tag = "R7 R10";
    for (int i = 0; i < D + 1; i++) begin
      host_tx_wr = 1; host_tx_wdata = 8'(i); tick();
    end
    tx_flush_req = 1; tick();
    for (int i = 0; i < FC; i++) tick();

    // mixed random traffic
    tag = "RND R2 R3 R5 R7 R8 R9 R10 R11 R12";
    for (int i = 0; i < 3000; i++) begin
      eng_en        = ($urandom_range(0, 3) != 0);
      host_tx_wr    = ($urandom_range(0, 2) == 0);
      host_tx_wdata = 8'($urandom_range(0, 255));
      eng_tx_pop    = ($urandom_range(0, 3) == 0);
      eng_rx_push   = ($urandom_range(0, 2) == 0);
      eng_rx_data   = 8'($urandom_range(0, 255));
      host_rx_rd    = ($urandom_range(0, 3) == 0);
      tx_flush_req  = ($urandom_range(0, 80) == 0);
      rx_flush_req  = ($urandom_range(0, 80) == 0);
      tx_ovr_clr    = ($urandom_range(0, 20) == 0);
      tx_thr_wr     = ($urandom_range(0, 40) == 0);
      rx_thr_wr     = ($urandom_range(0, 40) == 0);
      thr_wdata     = 4'($urandom_range(0, 15));
      tick();
    end

    done = 1;
    summary();
    $finish;
  end

endmodule